// File: doc/BRIEF.md
# Three-Way Intersection Light Controller

This block runs the green lights for three approaches to an intersection: a north-going lane, a south-going lane and an east-going lane. Each lane has a car-present input and a green output. A car sensed on a lane leaves a pending request that stays set until that lane has been served. North and south may be green at the same time. East has priority over both of them.

A single hold flag guards the crossing. It is set whenever north or south goes green, and east may only turn green while it is clear. The difficult cases are the ones where the north and south lanes change state on the same clock edge. If the flag is cleared wrongly there, east collides with north or south. If it is left set wrongly, east is locked out for good.

All state lives in flip-flops, and every green output is driven straight from a register. Reset is asynchronous and active-low.

Top module: `xing_light_ctrl`

## Requirements
- R1: While reset is asserted, all three green outputs are 0, every pending request is cleared and the hold flag is clear.
- R2: A lane's sense input high on a clock edge leaves that lane's pending request set from the next cycle on. The request is cleared only on the edge where that lane's green turns off.
- R3: North (or south) turns green on the next edge when its request is pending, it is not already green and no east request is pending. The hold flag is set on the same edge.
- R4: A green north, south or east light turns off on the next edge once its sense input is low, and its pending request is cleared on that edge.
- R5: East turns green on the next edge when its request is pending, the hold flag is clear and east is not already green.
- R6: When south turns off, it clears the hold flag only if north is neither green nor turning green on that same edge.
- R7: When north turns off, it clears the hold flag if south is not green or south's sense input is low, so the flag falls when both lanes turn off together.
- R8: Hold-flag writes from the south rules override those from the north rules on the same edge. With no write, the flag keeps its value.
- R9: East is never green in the same cycle as north or south. The hold flag is set in every cycle in which north or south is green.
- R10: Assume a car on a green lane always leaves within a few cycles. Then every sensed car is given green within 32 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_n | input | 1 | Car present on the north-going lane |
| sense_s | input | 1 | Car present on the south-going lane |
| sense_e | input | 1 | Car present on the east-going lane |
| go_n | output | 1 | North-going green light |
| go_s | output | 1 | South-going green light |
| go_e | output | 1 | East-going green light |

## Verification
The north and south turn-off rules can fire on the same edge. South turning off can also coincide with north turning green. In both cases the two lanes make competing writes to the hold flag. Directed sequences set up each coincidence: both lanes drop their cars together while an east car arrives, and south drops its car on the edge where a pending north request is granted while an east car arrives. The result is judged by whether east goes green exactly when the flag should be clear, and never while north is lit. A random phase with cars that leave on their own compares every output against a bench model each cycle and tracks how long each lane has waited.

// File: rtl/xing_pkg.sv
package xing_pkg;
  localparam int NUM_DIR = 3;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_S = 2'd1,
    DIR_E = 2'd2
  } dir_e;

  typedef struct packed {
    logic turn_on;
    logic turn_off;
  } lamp_evt_t;
endpackage

// File: rtl/xing_req_bank.sv
module xing_req_bank
  import xing_pkg::*;
#(
  parameter int N = NUM_DIR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sense,
  input  logic [N-1:0] clr,
  output logic [N-1:0] req
);
  logic [N-1:0] req_q, req_d, req_en;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // clear wins over a latch on the same edge
    always_comb begin
      req_en[i] = sense[i] | clr[i];
      req_d[i]  = ~clr[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         req_q[i] <= 1'b0;
      else if (req_en[i]) req_q[i] <= req_d[i];
    end

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sense[i] |=> req_q[i]);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !req_q[i]);
  end

  assign req = req_q;
endmodule

// File: rtl/xing_lamp.sv
module xing_lamp (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic block,
  input  logic sense,
  output logic go,
  output logic turn_on,
  output logic turn_off
);
  logic go_q, go_d, go_en;

  always_comb begin
    turn_on  = req & ~go_q & ~block;
    turn_off = go_q & ~sense;
    go_en    = turn_on | turn_off;
    go_d     = turn_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     go_q <= 1'b0;
    else if (go_en) go_q <= go_d;
  end

  assign go = go_q;

  assert_lamp_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !sense) |=> !go_q);
  // R3 for north/south slices, R5 for the east slice
  assert_lamp_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !go_q && !block) |=> go_q);
endmodule

// File: rtl/xing_hold.sv
module xing_hold
  import xing_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lamp_evt_t evt_n,
  input  lamp_evt_t evt_s,
  input  logic      go_n,
  input  logic      go_s,
  input  logic      sense_s,
  output logic      hold
);
  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    // north rules (lower precedence)
    if (evt_n.turn_on)
      hold_d = 1'b1;
    else if (evt_n.turn_off && (!go_s || !sense_s))
      hold_d = 1'b0;
    // south rules (higher precedence)
    if (evt_s.turn_on)
      hold_d = 1'b1;
    else if (evt_s.turn_off && !(go_n || evt_n.turn_on))
      hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign hold = hold_q;

  assert_ns_on_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_n.turn_on || evt_s.turn_on) |=> hold_q);
  assert_south_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_s.turn_on && evt_n.turn_off) |=> hold_q);
endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
  import xing_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sense_n,
  input  logic sense_s,
  input  logic sense_e,
  output logic go_n,
  output logic go_s,
  output logic go_e
);
  logic [NUM_DIR-1:0] sense_v, req_v, go_v, block_v, on_v, off_v;
  logic               hold;
  lamp_evt_t          evt_n, evt_s;

  assign sense_v = {sense_e, sense_s, sense_n};

  xing_req_bank #(.N(NUM_DIR)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .sense (sense_v),
    .clr   (off_v),
    .req   (req_v)
  );

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_lane
    if (g == int'(DIR_E)) begin : g_east
      assign block_v[g] = hold;
    end else begin : g_ns
      assign block_v[g] = req_v[DIR_E];
    end

    xing_lamp u_lamp (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_v[g]),
      .block    (block_v[g]),
      .sense    (sense_v[g]),
      .go       (go_v[g]),
      .turn_on  (on_v[g]),
      .turn_off (off_v[g])
    );
  end

  assign evt_n = '{turn_on: on_v[DIR_N], turn_off: off_v[DIR_N]};
  assign evt_s = '{turn_on: on_v[DIR_S], turn_off: off_v[DIR_S]};

  xing_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_n   (evt_n),
    .evt_s   (evt_s),
    .go_n    (go_v[DIR_N]),
    .go_s    (go_v[DIR_S]),
    .sense_s (sense_s),
    .hold    (hold)
  );

  assign go_n = go_v[DIR_N];
  assign go_s = go_v[DIR_S];
  assign go_e = go_v[DIR_E];

  assert_no_cross_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_e && (go_n || go_s)));
  assert_hold_covers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go_n || go_s) |-> hold);
  assert_east_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v[DIR_E] && !hold && !go_e) |=> go_e);
  assert_south_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go_s && !sense_s && go_n && sense_n) |=> hold);
  assert_both_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_n && !sense_n && go_s && !sense_s) |=> !hold);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (!go_n && !go_s && !go_e && !hold && req_v == '0));
endmodule

// File: tb/sim_xing_light_ctrl.sv
`timescale 1ns/1ps
module sim_xing_light_ctrl;
  localparam int WAIT_BOUND = 32;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0;
  logic rst_n;
  logic sn, ss, se;
  logic gn, gs, ge;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  xing_light_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .sense_n(sn), .sense_s(ss), .sense_e(se),
    .go_n(gn), .go_s(gs), .go_e(ge)
  );

  // reference model built from the requirements; index 0=N 1=S 2=E
  logic [2:0] m_go, m_req;
  logic       m_hold;

  always @(posedge clk or negedge rst_n) begin
    logic [2:0] sv, on, off;
    logic       h;
    if (!rst_n) begin
      m_go = '0; m_req = '0; m_hold = 1'b0;
    end else begin
      sv     = {se, ss, sn};
      on[0]  = m_req[0] & ~m_go[0] & ~m_req[2];
      on[1]  = m_req[1] & ~m_go[1] & ~m_req[2];
      on[2]  = m_req[2] & ~m_go[2] & ~m_hold;
      off    = m_go & ~sv;
      h      = m_hold;
      if (on[0]) h = 1'b1;
      else if (off[0] && (!m_go[1] || !sv[1])) h = 1'b0;
      if (on[1]) h = 1'b1;
      else if (off[1] && !(m_go[0] || on[0])) h = 1'b0;
      m_req  = (m_req | sv) & ~off;
      m_go   = (m_go | on) & ~off;
      m_hold = h;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 R4 north green vs model", gn, m_go[0]);
      chk("R3 R4 south green vs model", gs, m_go[1]);
      chk("R5 east green vs model", ge, m_go[2]);
      chk("R9 east crossing north/south", ge & (gn | gs), 1'b0);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    logic [2:0] car;
    int         hold_c [3];
    int         wait_c [3];
    logic [2:0] gv;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sn = 0; ss = 0; se = 0;
    repeat (3) step();
    chk("R1 north off in reset", gn, 1'b0);
    chk("R1 south off in reset", gs, 1'b0);
    chk("R1 east off in reset", ge, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 outputs stay off after reset", gn | gs | ge, 1'b0);

    // R2 R3 R4: single-cycle north pulse is remembered
    sn = 1; step(); sn = 0; step();
    chk("R2 sticky north request grants green", gn, 1'b1);
    step();
    chk("R4 north off once sense low", gn, 1'b0);
    step();

    // R3 R5: pending east request blocks north; east goes first (hold clear, R1)
    se = 1; sn = 1; step(); step();
    chk("R5 east green with hold clear", ge, 1'b1);
    chk("R3 north held back by east request", gn, 1'b0);
    se = 0; step();
    chk("R4 east off when sense low", ge, 1'b0);
    step();
    chk("R3 north green after east served", gn, 1'b1);
    sn = 0; step(); step();

    // R7: north and south turn off on the same edge while east arrives
    sn = 1; ss = 1; step(); step();
    chk("R3 north and south green together", gn & gs, 1'b1);
    sn = 0; ss = 0; se = 1; step();
    chk("R7 both north and south off", gn | gs, 1'b0);
    step();
    chk("R7 hold cleared so east is served", ge, 1'b1);
    se = 0; step(); step();

    // R6 R8: south turns off on the edge north turns on, east arriving
    ss = 1; step(); step();
    chk("R3 south green", gs, 1'b1);
    sn = 1; step();
    ss = 0; se = 1; step();
    chk("R6 north turns on as south turns off", gn, 1'b1);
    chk("R6 south off", gs, 1'b0);
    step();
    chk("R6 hold kept, east waits", ge, 1'b0);
    step();
    chk("R8 hold kept, east still waits", ge, 1'b0);
    sn = 0; step();
    chk("R4 north off", gn, 1'b0);
    step();
    chk("R6 east served after hold released", ge, 1'b1);
    se = 0; step(); step();

    // R10: random cars that leave a green light within a few cycles
    car = '0;
    for (int d = 0; d < 3; d++) begin hold_c[d] = 0; wait_c[d] = 0; end
    for (int c = 0; c < RAND_CYCLES; c++) begin
      gv = {ge, gs, gn};
      for (int d = 0; d < 3; d++) begin
        if (car[d]) begin
          if (gv[d]) begin
            if (wait_c[d] > 0) begin
              n_cmp++;
              wait_c[d] = 0;
            end
            if (hold_c[d] == 0) car[d] = 1'b0;
            else hold_c[d]--;
          end else begin
            wait_c[d]++;
            if (wait_c[d] == WAIT_BOUND) begin
              n_bad++;
              $display("FAIL R10 lane %0d waited: actual=%0d expected<%0d",
                       d, wait_c[d], WAIT_BOUND);
            end
          end
        end else if (!gv[d] && ($urandom % 5) == 0) begin
          car[d]    = 1'b1;
          hold_c[d] = int'($urandom % 4);
        end
      end
      sn = car[0]; ss = car[1]; se = car[2];
      step();
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule